// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Block

This block holds the software-visible configuration and status of an Ethernet MAC behind a simple word-wide request bus. It covers the operating mode with the receive and transmit enables, the station address, the multicast hash filter, two VLAN tag words, eight wake-up filter words, system control and status, receive and transmit status with sticky copies and interrupt enables, two counter-interrupt status and enable pairs, and two banks of saturating statistics counters. The frame datapath drives event vectors and counter increment strobes into the block and takes the enable bits back out.

A request is presented for one cycle on `req_valid`. The block answers one cycle later on `rsp_valid`, with registered read data and an error flag. Each register has its own write behaviour: plain storage, write-one-to-clear under a mask, write-ignored status, or an action. A window of offsets kept for precision-time registers reads as zero and ignores writes. Every other offset is reported as an error.

Register offsets (bytes): mode 0x000 (bit 0 receive enable, bit 1 transmit enable), station address low 0x004, high 0x008, hash low 0x00C, high 0x010, VLAN A 0x014, VLAN B 0x018, wake control 0x01C, wake filter words 0x020–0x03C, system control 0x040, system status 0x044, RX status 0x048, RX sticky 0x04C, RX interrupt enable 0x050, TX status 0x054, TX sticky 0x058, TX interrupt enable 0x05C, counter control 0x060, RX counter interrupt status 0x064 / enable 0x068, TX counter interrupt status 0x06C / enable 0x070, time window 0x080–0x0FC, RX counters from 0x100 and TX counters from 0x180, one word each.

Top module: `emac_csr`

## Requirements
- R1: Only accesses with `req_size` = 2'b10 and `req_addr[1:0]` = 0 are accepted. Any other access gets `rsp_err` = 1, read data 0, and changes no register.
- R2: Every request cycle is answered exactly one cycle later by `rsp_valid` = 1. Write responses carry data 0.
- R3: After reset the station address low word reads 0xFFFFFFFF, the station address high word 0x0000FFFF, both VLAN words 0x0000FFFF, system control 0x00003F00, counter control 0x0000000A, and all other registers 0.
- R4: Mode, station address, hash, VLAN, wake filter, system control and all interrupt-enable registers read back the last value written.
- R5: `rx_en` and `tx_en` mirror mode bits 0 and 1. A write that takes bit 0 from 0 to 1 clears the RX-done flag (RX status bit 12). A write that takes bit 1 from 0 to 1 clears the TX-done flag (TX status bit 1). An event that sets the flag in the same cycle wins over the clear.
- R6: RX and TX status bits are set by `rx_evt` and `tx_evt` and held. Writes to both status registers are ignored.
- R7: RX and TX sticky registers, set by the same events, and the two counter-interrupt status registers, set by `cnt_rx_irq_evt` and `cnt_tx_irq_evt`, clear every bit written with 1. An event wins over a clear in the same cycle.
- R8: System status bits under mask 0x1E are set by `sys_evt` and cleared by writing 1. The other bits show `sys_evt` of the previous cycle and ignore writes.
- R9: Wake control bits under mask 0xF20 are set by `wake_evt` and cleared by writing 1. The other bits are plain storage.
- R10: Writing counter control with bit 0 = 1 zeroes every RX and TX counter in that cycle. Bit 0 always reads 0, the other bits are stored, and the clear wins over an increment in the same cycle.
- R11: Each counter adds 1 for every cycle its increment strobe is high and stops at all-ones. Counters ignore bus writes.
- R12: Offsets 0x080 to 0x0FC read as 0 without error and ignore writes.
- R13: Offsets outside the map, including counter slots beyond the configured count, return `rsp_err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Access size, 2'b10 = 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Invalid access |
| rsp_rdata | output | 32 | Registered read data |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable |
| rx_evt | input | 32 | RX status/sticky set pulses |
| tx_evt | input | 32 | TX status/sticky set pulses |
| sys_evt | input | 32 | System status events |
| wake_evt | input | 32 | Wake control set pulses |
| cnt_rx_irq_evt | input | 32 | RX counter interrupt set pulses |
| cnt_tx_irq_evt | input | 32 | TX counter interrupt set pulses |
| rx_cnt_inc | input | N_RX_CNT | RX counter increment strobes |
| tx_cnt_inc | input | N_TX_CNT | TX counter increment strobes |

## Verification
The bench goes after the partial write-one-to-clear masks. A design that applied the system-status or wake-control mask to every bit would lose the plain wake bits or clear live status bits. It checks that a repeated enable write leaves the done flag alone and that an event in the same cycle as the rising enable survives. A design that cleared on level instead of edge, or let the clear win, would drop a completion. Counters are run past all-ones and cleared while incrementing, which shows a wrap or a lost clear. Writes to status, counter and time-window offsets, undersized and misaligned accesses, and holes in the map confirm that nothing changes and that errors appear only where they belong.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;

    localparam int unsigned DW          = 32;
    localparam int unsigned WAKE_FLT_N  = 8;
    localparam int unsigned WF_IW       = $clog2(WAKE_FLT_N);

    // word indexes of the regions
    localparam int unsigned W_WAKEFLT   = 8;
    localparam int unsigned W_SYSCTL    = 16;
    localparam int unsigned W_TIME_LO   = 32;
    localparam int unsigned W_TIME_HI   = 63;
    localparam int unsigned W_RXCNT     = 64;
    localparam int unsigned W_TXCNT     = 96;

    localparam int unsigned MODE_RX_BIT = 0;
    localparam int unsigned MODE_TX_BIT = 1;
    localparam int unsigned RX_DONE_BIT = 12;
    localparam int unsigned TX_DONE_BIT = 1;

    localparam logic [DW-1:0] SYSSTAT_W1C = 32'h0000_001E;
    localparam logic [DW-1:0] WAKE_W1C    = 32'h0000_0F20;

    localparam logic [DW-1:0] RST_MAC_LO  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] RST_MAC_HI  = 32'h0000_FFFF;
    localparam logic [DW-1:0] RST_VLAN    = 32'h0000_FFFF;
    localparam logic [DW-1:0] RST_SYSCTL  = 32'h0000_3F00;
    localparam logic [DW-1:0] RST_CNTCTL  = 32'h0000_000A;

    typedef enum logic [4:0] {
        R_NONE, R_MODE, R_MACLO, R_MACHI, R_HASHLO, R_HASHHI, R_VLANA, R_VLANB,
        R_WAKECTL, R_WAKEFLT, R_SYSCTL, R_SYSSTAT, R_RXSTAT, R_RXSTKY, R_RXIEN,
        R_TXSTAT, R_TXSTKY, R_TXIEN, R_CNTCTL, R_CRXIRQ, R_CRXIEN, R_CTXIRQ,
        R_CTXIEN, R_TIME, R_RXCNT, R_TXCNT
    } reg_id_e;

    typedef struct packed {
        logic [DW-1:0]                 mode;
        logic [DW-1:0]                 mac_lo;
        logic [DW-1:0]                 mac_hi;
        logic [DW-1:0]                 hash_lo;
        logic [DW-1:0]                 hash_hi;
        logic [DW-1:0]                 vlan_a;
        logic [DW-1:0]                 vlan_b;
        logic [DW-1:0]                 wake_ctl;
        logic [WAKE_FLT_N-1:0][DW-1:0] wake_flt;
        logic [DW-1:0]                 sys_ctl;
        logic [DW-1:0]                 sys_stat;
        logic [DW-1:0]                 rx_stat;
        logic [DW-1:0]                 rx_stky;
        logic [DW-1:0]                 rx_ien;
        logic [DW-1:0]                 tx_stat;
        logic [DW-1:0]                 tx_stky;
        logic [DW-1:0]                 tx_ien;
        logic [DW-1:0]                 cnt_ctl;
        logic [DW-1:0]                 crx_irq;
        logic [DW-1:0]                 crx_ien;
        logic [DW-1:0]                 ctx_irq;
        logic [DW-1:0]                 ctx_ien;
        logic                          rsp_valid;
        logic                          rsp_err;
        logic [DW-1:0]                 rdata;
    } csr_t;

endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
    import emac_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned N_RX_CNT = 8,
    parameter int unsigned N_TX_CNT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_id_e           id,
    output logic [4:0]        idx
);
    localparam int unsigned WA = ADDR_W - 2;

    logic [WA-1:0] word;
    int unsigned   wi;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        wi  = 32'(word);
        id  = R_NONE;
        idx = '0;
        if (size == 2'b10 && addr[1:0] == 2'b00) begin
            if (wi < W_WAKEFLT) begin
                case (wi)
                    0:       id = R_MODE;
                    1:       id = R_MACLO;
                    2:       id = R_MACHI;
                    3:       id = R_HASHLO;
                    4:       id = R_HASHHI;
                    5:       id = R_VLANA;
                    6:       id = R_VLANB;
                    default: id = R_WAKECTL;
                endcase
            end else if (wi < W_WAKEFLT + WAKE_FLT_N) begin
                id  = R_WAKEFLT;
                idx = 5'(wi - W_WAKEFLT);
            end else if (wi >= W_SYSCTL && wi <= W_SYSCTL + 12) begin
                case (wi - W_SYSCTL)
                    0:       id = R_SYSCTL;
                    1:       id = R_SYSSTAT;
                    2:       id = R_RXSTAT;
                    3:       id = R_RXSTKY;
                    4:       id = R_RXIEN;
                    5:       id = R_TXSTAT;
                    6:       id = R_TXSTKY;
                    7:       id = R_TXIEN;
                    8:       id = R_CNTCTL;
                    9:       id = R_CRXIRQ;
                    10:      id = R_CRXIEN;
                    11:      id = R_CTXIRQ;
                    default: id = R_CTXIEN;
                endcase
            end else if (wi >= W_TIME_LO && wi <= W_TIME_HI) begin
                id = R_TIME;
            end else if (wi >= W_RXCNT && wi < W_RXCNT + N_RX_CNT) begin
                id  = R_RXCNT;
                idx = 5'(wi - W_RXCNT);
            end else if (wi >= W_TXCNT && wi < W_TXCNT + N_TX_CNT) begin
                id  = R_TXCNT;
                idx = 5'(wi - W_TXCNT);
            end
        end
    end
endmodule

// File: rtl/emac_csr_cnt_bank.sv
module emac_csr_cnt_bank #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [N-1:0]        inc,
    output logic [N-1:0][W-1:0] cnt_q
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] c_d;
        logic [W-1:0] c_q;

        always_comb begin
            c_d = c_q;
            if (clr) begin
                c_d = '0;
            end else if (inc[g] && c_q != {W{1'b1}}) begin
                c_d = c_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) c_q <= '0;
            else     c_q <= c_d;
        end

        assign cnt_q[g] = c_q;
    end
endmodule

// File: rtl/emac_csr.sv
module emac_csr
    import emac_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned N_RX_CNT = 8,
    parameter int unsigned N_TX_CNT = 8,
    parameter int unsigned CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [31:0]         rsp_rdata,
    output logic                rx_en,
    output logic                tx_en,
    input  logic [31:0]         rx_evt,
    input  logic [31:0]         tx_evt,
    input  logic [31:0]         sys_evt,
    input  logic [31:0]         wake_evt,
    input  logic [31:0]         cnt_rx_irq_evt,
    input  logic [31:0]         cnt_tx_irq_evt,
    input  logic [N_RX_CNT-1:0] rx_cnt_inc,
    input  logic [N_TX_CNT-1:0] tx_cnt_inc
);
    localparam int unsigned RX_IW = (N_RX_CNT > 1) ? $clog2(N_RX_CNT) : 1;
    localparam int unsigned TX_IW = (N_TX_CNT > 1) ? $clog2(N_TX_CNT) : 1;

    csr_t    s_d, s_q;
    reg_id_e dec_id;
    logic [4:0] dec_idx;
    logic    acc_ok, wr_hit, rd_hit, cnt_clr;
    logic [31:0] wdat, rmux;
    logic [N_RX_CNT-1:0][CNT_W-1:0] rx_cnt_q;
    logic [N_TX_CNT-1:0][CNT_W-1:0] tx_cnt_q;

    emac_csr_decode #(
        .ADDR_W   (ADDR_W),
        .N_RX_CNT (N_RX_CNT),
        .N_TX_CNT (N_TX_CNT)
    ) u_dec (
        .addr (req_addr),
        .size (req_size),
        .id   (dec_id),
        .idx  (dec_idx)
    );

    emac_csr_cnt_bank #(.N(N_RX_CNT), .W(CNT_W)) u_rx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (rx_cnt_inc),
        .cnt_q (rx_cnt_q)
    );

    emac_csr_cnt_bank #(.N(N_TX_CNT), .W(CNT_W)) u_tx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (tx_cnt_inc),
        .cnt_q (tx_cnt_q)
    );

    assign acc_ok = (dec_id != R_NONE);
    assign wr_hit = req_valid & req_write & acc_ok;
    assign rd_hit = req_valid & ~req_write & acc_ok;
    assign wdat   = req_wdata;

    // read multiplexer, sees the values before this cycle's write
    always_comb begin
        rmux = '0;
        case (dec_id)
            R_MODE:    rmux = s_q.mode;
            R_MACLO:   rmux = s_q.mac_lo;
            R_MACHI:   rmux = s_q.mac_hi;
            R_HASHLO:  rmux = s_q.hash_lo;
            R_HASHHI:  rmux = s_q.hash_hi;
            R_VLANA:   rmux = s_q.vlan_a;
            R_VLANB:   rmux = s_q.vlan_b;
            R_WAKECTL: rmux = s_q.wake_ctl;
            R_WAKEFLT: rmux = s_q.wake_flt[dec_idx[WF_IW-1:0]];
            R_SYSCTL:  rmux = s_q.sys_ctl;
            R_SYSSTAT: rmux = s_q.sys_stat;
            R_RXSTAT:  rmux = s_q.rx_stat;
            R_RXSTKY:  rmux = s_q.rx_stky;
            R_RXIEN:   rmux = s_q.rx_ien;
            R_TXSTAT:  rmux = s_q.tx_stat;
            R_TXSTKY:  rmux = s_q.tx_stky;
            R_TXIEN:   rmux = s_q.tx_ien;
            R_CNTCTL:  rmux = s_q.cnt_ctl;
            R_CRXIRQ:  rmux = s_q.crx_irq;
            R_CRXIEN:  rmux = s_q.crx_ien;
            R_CTXIRQ:  rmux = s_q.ctx_irq;
            R_CTXIEN:  rmux = s_q.ctx_ien;
            R_RXCNT:   rmux = 32'(rx_cnt_q[dec_idx[RX_IW-1:0]]);
            R_TXCNT:   rmux = 32'(tx_cnt_q[dec_idx[TX_IW-1:0]]);
            default:   rmux = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        s_d     = s_q;
        cnt_clr = 1'b0;

        if (wr_hit) begin
            case (dec_id)
                R_MODE: begin
                    if (!s_q.mode[MODE_RX_BIT] && wdat[MODE_RX_BIT])
                        s_d.rx_stat[RX_DONE_BIT] = 1'b0;
                    if (!s_q.mode[MODE_TX_BIT] && wdat[MODE_TX_BIT])
                        s_d.tx_stat[TX_DONE_BIT] = 1'b0;
                    s_d.mode = wdat;
                end
                R_MACLO:   s_d.mac_lo  = wdat;
                R_MACHI:   s_d.mac_hi  = wdat;
                R_HASHLO:  s_d.hash_lo = wdat;
                R_HASHHI:  s_d.hash_hi = wdat;
                R_VLANA:   s_d.vlan_a  = wdat;
                R_VLANB:   s_d.vlan_b  = wdat;
                R_WAKECTL: s_d.wake_ctl = (s_q.wake_ctl & WAKE_W1C & ~wdat)
                                        | (wdat & ~WAKE_W1C);
                R_WAKEFLT: s_d.wake_flt[dec_idx[WF_IW-1:0]] = wdat;
                R_SYSCTL:  s_d.sys_ctl = wdat;
                R_SYSSTAT: s_d.sys_stat = s_q.sys_stat & ~(wdat & SYSSTAT_W1C);
                R_RXSTKY:  s_d.rx_stky = s_q.rx_stky & ~wdat;
                R_RXIEN:   s_d.rx_ien  = wdat;
                R_TXSTKY:  s_d.tx_stky = s_q.tx_stky & ~wdat;
                R_TXIEN:   s_d.tx_ien  = wdat;
                R_CNTCTL: begin
                    s_d.cnt_ctl = {wdat[31:1], 1'b0};
                    cnt_clr     = wdat[0];
                end
                R_CRXIRQ:  s_d.crx_irq = s_q.crx_irq & ~wdat;
                R_CRXIEN:  s_d.crx_ien = wdat;
                R_CTXIRQ:  s_d.ctx_irq = s_q.ctx_irq & ~wdat;
                R_CTXIEN:  s_d.ctx_ien = wdat;
                default: ;
            endcase
        end

        // hardware events are merged last so they win over clears
        s_d.rx_stat  = s_d.rx_stat | rx_evt;
        s_d.rx_stky  = s_d.rx_stky | rx_evt;
        s_d.tx_stat  = s_d.tx_stat | tx_evt;
        s_d.tx_stky  = s_d.tx_stky | tx_evt;
        s_d.sys_stat = (s_d.sys_stat & SYSSTAT_W1C) | sys_evt;
        s_d.wake_ctl = s_d.wake_ctl | (wake_evt & WAKE_W1C);
        s_d.crx_irq  = s_d.crx_irq | cnt_rx_irq_evt;
        s_d.ctx_irq  = s_d.ctx_irq | cnt_tx_irq_evt;

        s_d.rsp_valid = req_valid;
        s_d.rsp_err   = req_valid & ~acc_ok;
        s_d.rdata     = rd_hit ? rmux : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.mac_lo  <= RST_MAC_LO;
            s_q.mac_hi  <= RST_MAC_HI;
            s_q.vlan_a  <= RST_VLAN;
            s_q.vlan_b  <= RST_VLAN;
            s_q.sys_ctl <= RST_SYSCTL;
            s_q.cnt_ctl <= RST_CNTCTL;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_err   = s_q.rsp_err;
    assign rsp_rdata = s_q.rdata;
    assign rx_en     = s_q.mode[MODE_RX_BIT];
    assign tx_en     = s_q.mode[MODE_TX_BIT];

endmodule

// File: rtl/emac_csr_chk.sv
module emac_csr_chk
    import emac_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              rx_en,
    input logic [31:0]       rx_evt,
    input logic [31:0]       rx_stat_q,
    input logic              cnt_clr,
    input logic [CNT_W-1:0]  rx_cnt0
);
    logic time_rd;
    assign time_rd = req_valid && !req_write && req_size == 2'b10 && req_addr[1:0] == 2'b00
                     && 32'(req_addr) >= 32'h80 && 32'(req_addr) <= 32'hFC;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R1
    size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != 2'b10) |=> rsp_err);

    // R1
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == 32'h0));

    // R12
    time_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        time_rd |=> (rsp_rdata == 32'h0 && !rsp_err));

    // R10
    clr_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (rx_cnt0 == '0));

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt0 == {CNT_W{1'b1}} && !cnt_clr) |=> (rx_cnt0 == {CNT_W{1'b1}}));

    // R5
    rx_done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_en) && !$past(rx_evt[RX_DONE_BIT])) |-> !rx_stat_q[RX_DONE_BIT]);

endmodule

bind emac_csr emac_csr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .rx_en     (rx_en),
    .rx_evt    (rx_evt),
    .rx_stat_q (s_q.rx_stat),
    .cnt_clr   (cnt_clr),
    .rx_cnt0   (rx_cnt_q[0])
);

// File: tb/emac_csr_tb.sv
module emac_csr_tb;
    localparam int NRX = 8;
    localparam int NTX = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rx_en, tx_en;
    logic [31:0] rsp_rdata;
    logic [31:0] rx_evt = '0, tx_evt = '0, sys_evt = '0, wake_evt = '0;
    logic [31:0] cnt_rx_irq_evt = '0, cnt_tx_irq_evt = '0;
    logic [NRX-1:0] rx_cnt_inc = '0;
    logic [NTX-1:0] tx_cnt_inc = '0;

    logic [31:0]    side_rx_evt = '0;
    logic [NRX-1:0] side_rx_inc = '0;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rd;
    logic        er, last_valid;

    always #2 clk = ~clk;

    emac_csr #(.ADDR_W(9), .N_RX_CNT(NRX), .N_TX_CNT(NTX), .CNT_W(4)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rx_en(rx_en), .tx_en(tx_en),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .sys_evt(sys_evt), .wake_evt(wake_evt),
        .cnt_rx_irq_evt(cnt_rx_irq_evt), .cnt_tx_irq_evt(cnt_tx_irq_evt),
        .rx_cnt_inc(rx_cnt_inc), .tx_cnt_inc(tx_cnt_inc)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  req;
        logic [8:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd3,  9'h000, 32'h0,         32'h0000_0000, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h004, 32'h0,         32'hFFFF_FFFF, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h008, 32'h0,         32'h0000_FFFF, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h014, 32'h0,         32'h0000_FFFF, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h018, 32'h0,         32'h0000_FFFF, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h040, 32'h0,         32'h0000_3F00, 1'b0}, // R3
        '{1'b0, 4'd3,  9'h060, 32'h0,         32'h0000_000A, 1'b0}, // R3
        '{1'b1, 4'd4,  9'h00C, 32'h1234_5678, 32'h0,         1'b0}, // R4
        '{1'b0, 4'd4,  9'h00C, 32'h0,         32'h1234_5678, 1'b0}, // R4
        '{1'b1, 4'd4,  9'h028, 32'hA5A5_0F0F, 32'h0,         1'b0}, // R4
        '{1'b0, 4'd4,  9'h028, 32'h0,         32'hA5A5_0F0F, 1'b0}, // R4
        '{1'b1, 4'd6,  9'h048, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R6
        '{1'b0, 4'd6,  9'h048, 32'h0,         32'h0000_0000, 1'b0}, // R6
        '{1'b1, 4'd12, 9'h0A0, 32'hDEAD_BEEF, 32'h0,         1'b0}, // R12
        '{1'b0, 4'd12, 9'h0A0, 32'h0,         32'h0000_0000, 1'b0}, // R12
        '{1'b0, 4'd13, 9'h074, 32'h0,         32'h0000_0000, 1'b1}, // R13
        '{1'b0, 4'd13, 9'h1FC, 32'h0,         32'h0000_0000, 1'b1}, // R13
        '{1'b1, 4'd13, 9'h07C, 32'h1,         32'h0000_0000, 1'b1}  // R13
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [8:0] addr, input logic [31:0] wd,
                       input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_size = sz;
        rx_evt = side_rx_evt; rx_cnt_inc = side_rx_inc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'b10;
        rx_evt = '0; rx_cnt_inc = '0; side_rx_evt = '0; side_rx_inc = '0;
        rd = rsp_rdata; er = rsp_err; last_valid = rsp_valid;
    endtask

    task automatic wr32(input logic [8:0] addr, input logic [31:0] wd);
        acc(1'b1, addr, wd, 2'b10);
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] addr, input logic [31:0] exp);
        acc(1'b0, addr, 32'h0, 2'b10);
        chk(tag, rd, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].wr, VECS[i].addr, VECS[i].wdata, 2'b10);
            chk($sformatf("R%0d vec %0d err", VECS[i].req, i), 32'(er), 32'(VECS[i].err));
            if (!VECS[i].wr)
                chk($sformatf("R%0d vec %0d data", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R2: response one cycle later, then gone
        acc(1'b0, 9'h004, 32'h0, 2'b10);
        chk("R2 rsp_valid", 32'(last_valid), 32'h1);
        @(negedge clk);
        chk("R2 rsp_valid drop", 32'(rsp_valid), 32'h0);

        // R1: undersized write and misaligned read
        acc(1'b1, 9'h00C, 32'h0, 2'b01);
        chk("R1 size err", 32'(er), 32'h1);
        rd_chk("R1 no effect", 9'h00C, 32'h1234_5678);
        acc(1'b0, 9'h00E, 32'h0, 2'b10);
        chk("R1 misalign err", 32'(er), 32'h1);
        chk("R1 err data", rd, 32'h0);

        // R8: system status partial W1C
        @(negedge clk); sys_evt = 32'h0000_001F;
        @(negedge clk); sys_evt = '0;
        rd_chk("R8 set", 9'h044, 32'h0000_001E);
        wr32(9'h044, 32'h0000_0006);
        rd_chk("R8 w1c", 9'h044, 32'h0000_0018);
        wr32(9'h044, 32'hFFFF_FFE1);
        rd_chk("R8 unmasked", 9'h044, 32'h0000_0018);

        // R9: wake control
        @(negedge clk); wake_evt = 32'hFFFF_FFFF;
        @(negedge clk); wake_evt = '0;
        rd_chk("R9 set", 9'h01C, 32'h0000_0F20);
        wr32(9'h01C, 32'h0000_0005);
        rd_chk("R9 plain", 9'h01C, 32'h0000_0F25);
        wr32(9'h01C, 32'h0000_0120);
        rd_chk("R9 w1c", 9'h01C, 32'h0000_0E00);

        // R6, R5, R7: RX status and done flag
        @(negedge clk); rx_evt = 32'h0000_1001;
        @(negedge clk); rx_evt = '0;
        rd_chk("R6 rx stat", 9'h048, 32'h0000_1001);
        rd_chk("R7 rx sticky", 9'h04C, 32'h0000_1001);
        wr32(9'h000, 32'h0000_0003);
        chk("R5 rx_en", 32'(rx_en), 32'h1);
        chk("R5 tx_en", 32'(tx_en), 32'h1);
        rd_chk("R5 rx done cleared", 9'h048, 32'h0000_0001);
        rd_chk("R7 sticky kept", 9'h04C, 32'h0000_1001);
        wr32(9'h04C, 32'h0000_1000);
        rd_chk("R7 sticky w1c", 9'h04C, 32'h0000_0001);
        @(negedge clk); rx_evt = 32'h0000_1000;
        @(negedge clk); rx_evt = '0;
        wr32(9'h000, 32'h0000_0003);
        rd_chk("R5 no rise keeps", 9'h048, 32'h0000_1001);
        wr32(9'h000, 32'h0000_0000);
        @(negedge clk); tx_evt = 32'h0000_0002;
        @(negedge clk); tx_evt = '0;
        rd_chk("R6 tx stat", 9'h054, 32'h0000_0002);
        wr32(9'h000, 32'h0000_0002);
        rd_chk("R5 tx done cleared", 9'h054, 32'h0000_0000);
        side_rx_evt = 32'h0000_1000;
        wr32(9'h000, 32'h0000_0003);
        rd_chk("R5 event wins", 9'h048, 32'h0000_1001);

        // R7: counter interrupt status
        @(negedge clk); cnt_rx_irq_evt = 32'h3; cnt_tx_irq_evt = 32'h8000_0000;
        @(negedge clk); cnt_rx_irq_evt = '0; cnt_tx_irq_evt = '0;
        wr32(9'h064, 32'h1);
        rd_chk("R7 cnt rx irq", 9'h064, 32'h2);
        rd_chk("R7 cnt tx irq", 9'h06C, 32'h8000_0000);

        // R11: counting, read-only
        repeat (3) begin
            @(negedge clk); rx_cnt_inc = 8'h01;
            @(negedge clk); rx_cnt_inc = '0;
        end
        @(negedge clk); tx_cnt_inc = 8'h04;
        @(negedge clk); tx_cnt_inc = '0;
        rd_chk("R11 rx count", 9'h100, 32'h3);
        rd_chk("R11 tx count", 9'h188, 32'h1);
        wr32(9'h100, 32'h55);
        rd_chk("R11 read-only", 9'h100, 32'h3);

        // R10: clear all
        wr32(9'h060, 32'h0000_00A1);
        rd_chk("R10 ctl bit0", 9'h060, 32'h0000_00A0);
        rd_chk("R10 rx cleared", 9'h100, 32'h0);
        rd_chk("R10 tx cleared", 9'h188, 32'h0);

        // R11: saturation (4-bit counters here)
        @(negedge clk); rx_cnt_inc = 8'h02;
        repeat (20) @(negedge clk);
        rx_cnt_inc = '0;
        rd_chk("R11 saturate", 9'h104, 32'hF);

        // R10: clear beats increment
        side_rx_inc = 8'h02;
        wr32(9'h060, 32'h1);
        rd_chk("R10 clear wins", 9'h104, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule